// File: doc/BRIEF.md
# Streaming 3x3 Gradient Edge Detector

This block takes a stream of single-plane pixels and produces one edge bit per pixel. The input uses a valid/ready handshake and a frame-start flag on the first pixel of each frame. The two most recent rows are kept in a packed line store. Each accepted pixel completes one three-pixel column of a 3x3 window. The window is centred one row and one column behind the newest pixel.

Two orthogonal gradient kernels are applied to the window. A run-time select chooses the kernel family: Sobel, with centre weight 2, or Prewitt, with centre weight 1. The absolute values of the two gradients are summed and compared with a threshold. Window taps that fall outside the frame are filled by one of three border modes.

After the frame-start pixel, the block takes the frame size, kernel choice, threshold, border mode and fill constant from its configuration inputs and keeps them for the rest of the frame. After each row, it spends one cycle with the input closed to finish the right border. After the last row, it generates one extra row internally, so the bottom row of results drains without needing input from the next frame.

Top module: `grad_edge_stream`

## Requirements
- R1: A pixel is accepted on a rising clock edge where both `in_valid` and `in_ready` are high. While no frame is in progress, `in_ready` is high. Accepted pixels without `in_sof` are discarded and produce no output. An accepted pixel with `in_sof` set becomes row 0, column 0 of a new frame.
- R2: Within a frame of width W and height H (W ≥ 2, H ≥ 2), `in_ready` drops for exactly one cycle after each row's W-th pixel. After the last pixel of the frame, `in_ready` stays low for W+2 cycles and then returns high.
- R3: Each frame produces exactly W·H results, in raster order, each one qualified by `out_valid`. The first result carries `out_sof`, and no other result in the frame does.
- R4: With `cfg_method` = 0 (Sobel), the horizontal gradient is the right column minus the left column, with row weights 1,2,1. The vertical gradient is the bottom row minus the top row, with column weights 1,2,1.
- R5: With `cfg_method` = 1 (Prewitt), the same two differences are formed with weights 1,1,1.
- R6: The two absolute gradients are added without loss in DW+3 bits. `out_edge` is 1 only when that sum is strictly greater than `cfg_thresh`.
- R7: With `cfg_border` = 0 (copy), a tap outside the frame takes the value of the nearest pixel on the frame's edge.
- R8: With `cfg_border` = 1 (mirror), a tap one position outside the frame takes the pixel one position inside the frame, on the same line as the edge pixel (index 1 or size−2).
- R9: With `cfg_border` = 2 (fill), every tap outside the frame, corners included, takes `cfg_fill`.
- R10: Frame width, height, method, threshold, border mode and fill are taken when the frame-start pixel is accepted. Changing them during the frame has no effect on that frame.
- R11: `in_sof` on a pixel in the middle of a frame is ignored: the frame's results are unchanged.
- R12: Synchronous active-high `rst` cancels any frame in progress. It drives `out_valid` low and `in_ready` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | CW | Frame width in pixels (2..MAX_W) |
| cfg_height | input | RW | Frame height in rows (2..MAX_H) |
| cfg_method | input | 1 | Kernel family: 0 Sobel, 1 Prewitt |
| cfg_border | input | 2 | Border mode: 0 copy, 1 mirror, 2 fill |
| cfg_fill | input | DW | Constant used by fill mode |
| cfg_thresh | input | DW+3 | Edge threshold |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Pixel is row 0, column 0 |
| in_pix | input | DW | Pixel value |
| out_valid | output | 1 | Result valid |
| out_sof | output | 1 | Result is row 0, column 0 |
| out_edge | output | 1 | Edge bit |

## Verification
A wrong row or column counter appears within one row as a misplaced `in_ready` gap. At the end of the frame it also shows as a wrong count of results or of closed cycles. A fault in the line store or the window shift register corrupts results for interior pixels from the second output row onward. A wrong border substitution affects only the first and last result of each row and the first and last result rows. The bench therefore uses small frames, and it compares every result bit against an independent model, once for each combination of border mode and kernel. Threshold faults are tested at the exact sum value and at one below it.

// File: rtl/ges_pkg.sv
package ges_pkg;
  typedef enum logic [1:0] {
    BORDER_COPY   = 2'd0,
    BORDER_MIRROR = 2'd1,
    BORDER_FILL   = 2'd2
  } border_e;

  typedef enum logic {
    METH_SOBEL   = 1'b0,
    METH_PREWITT = 1'b1
  } method_e;
endpackage

// File: rtl/ges_frame_seq.sv
module ges_frame_seq #(
  parameter int CW = 11,
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_w,
  input  logic [RW-1:0] cfg_h,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          in_ready,
  output logic          step,
  output logic          load,
  output logic          wr_en,
  output logic [CW-1:0] wr_addr,
  output logic [CW-1:0] rd_addr,
  output logic          emit,
  output logic          first,
  output logic          top_edge,
  output logic          bot_edge,
  output logic          left_edge,
  output logic          right_edge
);
  // Slot grid per frame: rows 0..H, columns 0..W. Column W and row H are
  // internal flush slots that take no input.
  logic          busy_q, busy_d, flush;
  logic [CW-1:0] col_q, col_d, w_q;
  logic [RW-1:0] row_q, row_d, h_q;

  always_comb begin
    flush    = busy_q && ((col_q == w_q) || (row_q == h_q));
    in_ready = !flush;
    load     = !busy_q && in_valid && in_sof;
    step     = busy_q ? (flush || in_valid) : load;
    col_d    = col_q;
    row_d    = row_q;
    busy_d   = busy_q;
    if (step) begin
      if (!busy_q) begin
        busy_d = 1'b1;
        col_d  = CW'(1);
        row_d  = '0;
      end else if (col_q == w_q) begin
        col_d = '0;
        if (row_q == h_q) begin
          busy_d = 1'b0;
          row_d  = '0;
        end else begin
          row_d = row_q + 1'b1;
        end
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
      w_q    <= '0;
      h_q    <= '0;
    end else begin
      busy_q <= busy_d;
      col_q  <= col_d;
      row_q  <= row_d;
      if (load) begin
        w_q <= cfg_w;
        h_q <= cfg_h;
      end
    end
  end

  assign wr_en      = step && !flush;
  assign wr_addr    = col_q;
  assign rd_addr    = col_d;
  assign emit       = busy_q && (col_q != '0) && (row_q != '0);
  assign first      = (row_q == RW'(1)) && (col_q == CW'(1));
  assign top_edge   = (row_q == RW'(1));
  assign bot_edge   = busy_q && (row_q == h_q);
  assign left_edge  = (col_q == CW'(1));
  assign right_edge = busy_q && (col_q == w_q);

  // R1: a frame-start pixel accepted while idle opens a frame at slot (0,1)
  a_r1_start_on_sof: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy_q && (col_q == CW'(1)) && (row_q == '0)));

  // R2: after the final flush slot the input is open again
  a_r2_reopen_after_flush: assert property (@(posedge clk) disable iff (rst)
    (step && busy_q && (row_q == h_q) && (col_q == w_q)) |=> in_ready);
endmodule

// File: rtl/ges_line_store.sv
module ges_line_store #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_pix,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] older,
  output logic [DW-1:0] newer
);
  localparam int DEPTH = 1 << AW;

  // One word per column holds the two previous rows side by side.
  logic [2*DW-1:0] mem [DEPTH];
  logic [2*DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {rd_q[DW-1:0], wr_pix};
    rd_q <= mem[rd_addr];
  end

  assign older = rd_q[2*DW-1:DW];
  assign newer = rd_q[DW-1:0];

  // R2: the column being written is never the one being prefetched
  a_r2_addr_apart: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != rd_addr));
endmodule

// File: rtl/ges_window.sv
module ges_window
  import ges_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [1:0]         cfg_border,
  input  logic [DW-1:0]      cfg_fill,
  input  logic               step,
  input  logic               emit,
  input  logic               first,
  input  logic               top_edge,
  input  logic               bot_edge,
  input  logic               left_edge,
  input  logic               right_edge,
  input  logic [DW-1:0]      up_pix,
  input  logic [DW-1:0]      mid_pix,
  input  logic [DW-1:0]      low_pix,
  output logic [8:0][DW-1:0] win,
  output logic               win_v,
  output logic               win_sof
);
  border_e             mode_q;
  logic [DW-1:0]       fill_q;
  logic [2:0][DW-1:0]  col_l, col_c, col_r, col_in;
  logic                v_q, sof_q, lft_q, rgt_q;

  function automatic logic [DW-1:0] pick(border_e m, logic [DW-1:0] near_p,
                                         logic [DW-1:0] far_p, logic [DW-1:0] fill_p);
    case (m)
      BORDER_COPY:   return near_p;
      BORDER_MIRROR: return far_p;
      default:       return fill_p;
    endcase
  endfunction

  // Row borders are resolved as the column enters the window.
  always_comb begin
    col_in[1] = mid_pix;
    col_in[0] = top_edge ? pick(mode_q, mid_pix, low_pix, fill_q) : up_pix;
    col_in[2] = bot_edge ? pick(mode_q, mid_pix, up_pix, fill_q) : low_pix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= BORDER_COPY;
      fill_q <= '0;
      v_q    <= 1'b0;
      sof_q  <= 1'b0;
      lft_q  <= 1'b0;
      rgt_q  <= 1'b0;
    end else begin
      if (load) begin
        mode_q <= border_e'(cfg_border);
        fill_q <= cfg_fill;
      end
      v_q <= step && emit;
      if (step) begin
        sof_q <= first;
        lft_q <= left_edge;
        rgt_q <= right_edge;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      col_r <= col_in;
      col_c <= col_r;
      col_l <= col_c;
    end
  end

  // Column borders are resolved on the window outputs.
  for (genvar g = 0; g < 3; g++) begin : g_row
    assign win[g*3+0] = lft_q ? pick(mode_q, col_c[g], col_r[g], fill_q) : col_l[g];
    assign win[g*3+1] = col_c[g];
    assign win[g*3+2] = rgt_q ? pick(mode_q, col_c[g], col_l[g], fill_q) : col_r[g];
  end

  assign win_v   = v_q;
  assign win_sof = sof_q;
endmodule

// File: rtl/ges_gradient.sv
module ges_gradient
  import ges_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               cfg_method,
  input  logic [DW+2:0]      cfg_thresh,
  input  logic [8:0][DW-1:0] win,
  input  logic               win_v,
  input  logic               win_sof,
  output logic               out_valid,
  output logic               out_sof,
  output logic               out_edge
);
  localparam int SW = DW + 2;  // weighted three-tap sum
  localparam int MW = DW + 4;  // magnitude with one guard bit

  method_e       meth_q;
  logic [DW+2:0] thr_q;
  logic          dbl;
  logic [SW-1:0] gx_p, gx_n, gy_p, gy_n, ax, ay;
  logic [MW-1:0] mag;

  function automatic logic [SW-1:0] tap3(logic [DW-1:0] a, logic [DW-1:0] b,
                                         logic [DW-1:0] c, logic twice);
    logic [SW-1:0] bw;
    bw = twice ? {1'b0, b, 1'b0} : {2'b00, b};
    return SW'(a) + bw + SW'(c);
  endfunction

  function automatic logic [SW-1:0] absdiff(logic [SW-1:0] p, logic [SW-1:0] n);
    return (p >= n) ? (p - n) : (n - p);
  endfunction

  always_comb begin
    dbl  = (meth_q == METH_SOBEL);
    gx_p = tap3(win[2], win[5], win[8], dbl);
    gx_n = tap3(win[0], win[3], win[6], dbl);
    gy_p = tap3(win[6], win[7], win[8], dbl);
    gy_n = tap3(win[0], win[1], win[2], dbl);
    ax   = absdiff(gx_p, gx_n);
    ay   = absdiff(gy_p, gy_n);
    mag  = MW'(ax) + MW'(ay);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meth_q    <= METH_SOBEL;
      thr_q     <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_edge  <= 1'b0;
    end else begin
      if (load) begin
        meth_q <= method_e'(cfg_method);
        thr_q  <= cfg_thresh;
      end
      out_valid <= win_v;
      out_sof   <= win_v && win_sof;
      out_edge  <= win_v && (mag[DW+2:0] > thr_q);
    end
  end

  // R6: the gradient sum always fits in DW+3 bits
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    win_v |-> (mag[MW-1] == 1'b0));
endmodule

// File: rtl/grad_edge_stream.sv
module grad_edge_stream #(
  parameter int DW    = 8,
  parameter int MAX_W = 2000,
  parameter int MAX_H = 1200,
  localparam int CW = $clog2(MAX_W + 1),
  localparam int RW = $clog2(MAX_H + 1),
  localparam int TW = DW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  input  logic          cfg_method,
  input  logic [1:0]    cfg_border,
  input  logic [DW-1:0] cfg_fill,
  input  logic [TW-1:0] cfg_thresh,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sof,
  input  logic [DW-1:0] in_pix,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_edge
);
  logic               step, load, wr_en, emit, first;
  logic               top_edge, bot_edge, left_edge, right_edge;
  logic [CW-1:0]      wr_addr, rd_addr;
  logic [DW-1:0]      older, newer;
  logic [8:0][DW-1:0] win;
  logic               win_v, win_sof;

  ges_frame_seq #(.CW(CW), .RW(RW)) i_seq (
    .clk(clk), .rst(rst), .cfg_w(cfg_width), .cfg_h(cfg_height),
    .in_valid(in_valid), .in_sof(in_sof), .in_ready(in_ready),
    .step(step), .load(load), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .emit(emit), .first(first), .top_edge(top_edge), .bot_edge(bot_edge),
    .left_edge(left_edge), .right_edge(right_edge)
  );

  ges_line_store #(.DW(DW), .AW(CW)) i_lines (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_pix(in_pix),
    .rd_addr(rd_addr), .older(older), .newer(newer)
  );

  ges_window #(.DW(DW)) i_win (
    .clk(clk), .rst(rst), .load(load), .cfg_border(cfg_border), .cfg_fill(cfg_fill),
    .step(step), .emit(emit), .first(first), .top_edge(top_edge), .bot_edge(bot_edge),
    .left_edge(left_edge), .right_edge(right_edge),
    .up_pix(older), .mid_pix(newer), .low_pix(in_pix),
    .win(win), .win_v(win_v), .win_sof(win_sof)
  );

  ges_gradient #(.DW(DW)) i_grad (
    .clk(clk), .rst(rst), .load(load), .cfg_method(cfg_method), .cfg_thresh(cfg_thresh),
    .win(win), .win_v(win_v), .win_sof(win_sof),
    .out_valid(out_valid), .out_sof(out_sof), .out_edge(out_edge)
  );

  // R3: a frame marker on the output is always a qualified result
  a_r3_sof_qualified: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
endmodule

// File: tb/test_grad_edge_stream.sv
module test_grad_edge_stream;
  localparam int DW = 8, MAX_W = 64, MAX_H = 32;
  localparam int CW = $clog2(MAX_W + 1), RW = $clog2(MAX_H + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] cfg_width = CW'(8);
  logic [RW-1:0] cfg_height = RW'(4);
  logic cfg_method = 1'b0;
  logic [1:0] cfg_border = 2'd0;
  logic [DW-1:0] cfg_fill = '0;
  logic [DW+2:0] cfg_thresh = '0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [DW-1:0] in_pix = '0;
  logic in_ready, out_valid, out_sof, out_edge;

  grad_edge_stream #(.DW(DW), .MAX_W(MAX_W), .MAX_H(MAX_H)) i_grad_edge_stream (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_method(cfg_method), .cfg_border(cfg_border), .cfg_fill(cfg_fill),
    .cfg_thresh(cfg_thresh), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid), .out_sof(out_sof),
    .out_edge(out_edge)
  );

  always #5 clk = ~clk;

  int n_checks = 0, n_errors = 0;
  int img [MAX_H][MAX_W];
  int ew, eh, emeth, emode, efill, ethr;
  logic got_bit [MAX_H*MAX_W];
  logic got_sof [MAX_H*MAX_W];
  int ocnt = 0, sof_cnt = 0;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ocnt < MAX_H*MAX_W) begin
        got_bit[ocnt] = out_edge;
        got_sof[ocnt] = out_sof;
      end
      if (out_sof) sof_cnt++;
      ocnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic set_img(input int kind, input int seed);
    for (int r = 0; r < MAX_H; r++)
      for (int c = 0; c < MAX_W; c++)
        case (kind)
          0: img[r][c] = (r*37 + c*11 + seed*53 + ((r*c*7) ^ seed)) % 256;
          1: img[r][c] = 100;
          2: img[r][c] = (c >= r) ? 255 : 0;
          default: img[r][c] = (c >= 3) ? 200 : 0;
        endcase
  endtask

  function automatic int fetch(input int r, input int c);
    int rr, cc;
    if (r < 0 || r >= eh || c < 0 || c >= ew) begin
      if (emode == 2) return efill;
    end
    rr = r; cc = c;
    if (r < 0) rr = (emode == 0) ? 0 : -r;
    if (r >= eh) rr = (emode == 0) ? eh - 1 : 2*eh - 2 - r;
    if (c < 0) cc = (emode == 0) ? 0 : -c;
    if (c >= ew) cc = (emode == 0) ? ew - 1 : 2*ew - 2 - c;
    return img[rr][cc];
  endfunction

  function automatic int grad_sum(input int r, input int c);
    int k, gx, gy;
    k  = (emeth == 0) ? 2 : 1;
    gx = fetch(r-1, c+1) + k*fetch(r, c+1) + fetch(r+1, c+1)
       - fetch(r-1, c-1) - k*fetch(r, c-1) - fetch(r+1, c-1);
    gy = fetch(r+1, c-1) + k*fetch(r+1, c) + fetch(r+1, c+1)
       - fetch(r-1, c-1) - k*fetch(r-1, c) - fetch(r-1, c+1);
    if (gx < 0) gx = -gx;
    if (gy < 0) gy = -gy;
    return gx + gy;
  endfunction

  // Drives one frame and checks handshake gaps, counts, marker and every bit.
  task automatic run_frame(input string req, input int w, input int h, input int meth,
                           input int mode, input int fill, input int thr,
                           input bit gaps, input bit mid_sof, input bit flip);
    int flush_bad, lowcnt, mism, first_act, first_exp;
    ew = w; eh = h; emeth = meth; emode = mode; efill = fill; ethr = thr;
    @(negedge clk);
    cfg_width = CW'(w); cfg_height = RW'(h); cfg_method = meth[0];
    cfg_border = mode[1:0]; cfg_fill = DW'(fill); cfg_thresh = (DW+3)'(thr);
    ocnt = 0; sof_cnt = 0; flush_bad = 0;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        if (gaps && ((r*w + c) % 3 == 1)) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        in_pix   = DW'(img[r][c]);
        in_sof   = (r == 0 && c == 0) || (mid_sof && r == 1 && c == 2);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
      end
      if (r < h - 1) begin
        @(negedge clk);
        if (in_ready) flush_bad++;
      end
      if (flip && r == 0) begin
        cfg_method = ~cfg_method; cfg_border = 2'd2; cfg_fill = 8'hA5;
        cfg_thresh = 11'd3; cfg_width = CW'(w + 1); cfg_height = RW'(h + 2);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    lowcnt = 0;
    while (!in_ready && lowcnt < 1000) begin
      lowcnt++;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(flush_bad == 0, {req, " R2 row gap"}, flush_bad, 0);
    check(lowcnt == w + 2, {req, " R2 end drain"}, lowcnt, w + 2);
    check(ocnt == w*h, {req, " R3 count"}, ocnt, w*h);
    check(sof_cnt == 1 && got_sof[0] == 1'b1, {req, " R3 marker"}, sof_cnt, 1);
    mism = 0; first_act = 0; first_exp = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int e;
        e = (grad_sum(r, c) > thr) ? 1 : 0;
        if (int'(got_bit[r*w + c]) != e) begin
          if (mism == 0) begin first_act = int'(got_bit[r*w + c]); first_exp = e; end
          mism++;
        end
      end
    check(mism == 0, {req, " bits"}, mism, 0);
    if (mism != 0) $display("  first mismatch actual %0d expected %0d", first_act, first_exp);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R12 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R12 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_sobel_copy();
    set_img(0, 1);
    run_frame("R4,R7", 8, 5, 0, 0, 0, 150, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_prewitt_mirror();
    set_img(0, 2);
    run_frame("R5,R8", 7, 6, 1, 1, 0, 90, 1'b1, 1'b0, 1'b0);
    set_img(0, 5);
    run_frame("R8 minimum frame", 2, 2, 0, 1, 0, 40, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fill_value();
    set_img(2, 0);
    run_frame("R9", 6, 4, 0, 2, 255, 300, 1'b1, 1'b0, 1'b0);
    set_img(0, 3);
    run_frame("R9 prewitt", 5, 3, 1, 2, 17, 60, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_threshold();
    set_img(3, 0);
    run_frame("R6 at sum", 6, 4, 0, 0, 0, 800, 1'b0, 1'b0, 1'b0);
    check(got_bit[1*6 + 2] == 1'b0, "R6 sum equal to threshold", int'(got_bit[8]), 0);
    run_frame("R6 below sum", 6, 4, 0, 0, 0, 799, 1'b0, 1'b0, 1'b0);
    check(got_bit[1*6 + 2] == 1'b1, "R6 sum above threshold", int'(got_bit[8]), 1);
    set_img(1, 0);
    run_frame("R6 flat", 6, 3, 0, 1, 0, 0, 1'b0, 1'b0, 1'b0);
    set_img(2, 0);
    run_frame("R6 high contrast", 8, 8, 0, 0, 0, 1400, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_idle_drop();
    @(negedge clk);
    ocnt = 0;
    for (int i = 0; i < 3; i++) begin
      in_pix = DW'(250 - i); in_sof = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1 idle ready", int'(in_ready), 1);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(ocnt == 0, "R1 idle pixels produce nothing", ocnt, 0);
    set_img(0, 7);
    run_frame("R1 after dropped pixels", 6, 4, 0, 0, 0, 120, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mid_sof();
    set_img(0, 9);
    run_frame("R11", 7, 4, 0, 1, 0, 110, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_cfg_latch();
    set_img(0, 11);
    run_frame("R10", 6, 5, 0, 0, 0, 130, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset_midframe();
    @(negedge clk);
    cfg_width = CW'(8); cfg_height = RW'(4);
    for (int i = 0; i < 12; i++) begin
      in_pix = DW'(i*20); in_sof = (i == 0); in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R12 out_valid after mid-frame reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R12 in_ready after mid-frame reset", int'(in_ready), 1);
    set_img(0, 13);
    run_frame("R12 frame after reset", 6, 4, 1, 0, 0, 70, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sobel_copy();
    t_prewitt_mirror();
    t_fill_value();
    t_threshold();
    t_idle_drop();
    t_mid_sof();
    t_cfg_latch();
    t_reset_midframe();
    summary();
  end
endmodule